// File: doc/BRIEF.md
# Timer-Synchronized Parallel Output Port

This block is an 8-bit bidirectional parallel port controlled through a small register bus. Software does not write output data straight to the pins. It writes the data into a preload register. Each 4-bit half of the preload then moves into the output register when a strobe chosen for that half is high. The available strobes are a half-rate enable from the system clock and three timer pulses. Because each half uses its own strobe, output changes can line up with timer events. It also lets the two halves update at different moments.

Every pin has its own settings. A direction bit makes the pin an output or an input. A drive bit selects push-pull or open-drain. A function bit replaces the port data with a serial-channel signal on the pins that have one. Reads of the data address return the live pin levels, not the stored value. The serial channels and the timers are not part of this block. Their outputs reach the block as plain input ports.

Top module: `tsp_port`

## Requirements
- R1: After reset, every direction bit is 0, so `pad_oe` is 0x00. Both strobe selects are also 0, so reads at address 1 return 0x00.
- R2: A write to address 0 goes only to the preload. `pad_out` keeps its value until a selected strobe arrives.
- R3: With `bus_rd` high, a read at address 0 returns `pad_in` in the same cycle. With `bus_rd` low, `bus_rdata` is 0x00.
- R4: Address 1 holds the strobe select for the lower half in bits 1:0 and for the upper half in bits 5:4. The codes are 00 for the half-rate enable, 01 for timer A1, 10 for timer B1 and 11 for timer B2. Bits 7:6 and 3:2 are not stored and read as 0.
- R5: A half of the output register takes the preload half on the clock edge where its selected strobe is high. If a write to address 0 happens in that same cycle, the new data waits for the next strobe.
- R6: Address 4 is the direction register. A bit of 1 makes the pin an output. A bit of 0 keeps its `pad_oe` bit low. The register reads back as written.
- R7: Address 3 is the drive register. A bit of 0 gives push-pull, where `pad_oe` is 1 and `pad_out` is the pin value. A bit of 1 gives open-drain, where `pad_out` is 0 and `pad_oe` is the inverse of the pin value.
- R8: Reads of the drive register at address 3 return 0x00.
- R9: Address 2 is the function register, and it reads back as written. A bit of 1 sends the alternate signal to that pin: pin 6 takes `alt_txd[1]`, pin 2 takes `alt_txd[0]`, pins 5 and 4 take `alt_sclk[1]`, and pins 1 and 0 take `alt_sclk[0]`. Function bits 7 and 3 have no effect.
- R10: Addresses 5 to 7 ignore writes and read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read enable |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| strb_half | input | 1 | Half-rate clock enable |
| strb_ta1 | input | 1 | Timer A1 pulse |
| strb_tb1 | input | 1 | Timer B1 pulse |
| strb_tb2 | input | 1 | Timer B2 pulse |
| alt_txd | input | 2 | Serial data outputs of channels 1 and 0 |
| alt_sclk | input | 2 | Serial clock outputs of channels 1 and 0 |
| pad_in | input | 8 | Pin levels |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Pin output enables |

## Verification
Register writes and strobe transfers take effect on the clock edge that samples them. The result shows on `pad_out`, `pad_oe` and read data right after that edge, because the pad logic after the output register is combinational. Read data depends on `bus_rd`, `bus_addr` and `pad_in` within the same cycle. The bench drives its inputs on the falling edge and updates its model on the rising edge. It compares all three outputs two time units after each falling edge, once all these paths have settled. The directed checks follow the same rule. Each write or strobe pulse is followed by one full clock before the check, so it checks the state after exactly one transfer edge.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  localparam int PORT_W  = 8;
  localparam int NIB_W   = 4;
  localparam int NUM_NIB = PORT_W / NIB_W;
  localparam int ADDR_W  = 3;
  localparam int NUM_STRB = 4;

  typedef enum logic [1:0] {
    SEL_HALF = 2'd0,
    SEL_TA1  = 2'd1,
    SEL_TB1  = 2'd2,
    SEL_TB2  = 2'd3
  } strb_sel_e;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 3'd0,
    A_CTRL = 3'd1,
    A_FUNC = 3'd2,
    A_DRV  = 3'd3,
    A_DIR  = 3'd4
  } reg_addr_e;

  // alternate source kinds per pin
  localparam int ALT_NONE = 0;
  localparam int ALT_TXD0 = 1;
  localparam int ALT_TXD1 = 2;
  localparam int ALT_CLK0 = 3;
  localparam int ALT_CLK1 = 4;

  function automatic int alt_kind(int pin);
    case (pin)
      6:       return ALT_TXD1;
      5, 4:    return ALT_CLK1;
      2:       return ALT_TXD0;
      1, 0:    return ALT_CLK0;
      default: return ALT_NONE;
    endcase
  endfunction

  function automatic logic pick_strobe(logic [1:0] sel, logic [NUM_STRB-1:0] strb);
    case (sel)
      SEL_HALF: return strb[0];
      SEL_TA1:  return strb[1];
      SEL_TB1:  return strb[2];
      SEL_TB2:  return strb[3];
      default:  return 1'b0;
    endcase
  endfunction

  // returns {oe, out}
  function automatic logic [1:0] pad_drive(logic val, logic is_out, logic open_drain);
    logic oe;
    logic o;
    if (!is_out)         oe = 1'b0;
    else if (open_drain) oe = ~val;
    else                 oe = 1'b1;
    o = open_drain ? 1'b0 : val;
    return {oe, o};
  endfunction
endpackage

// File: rtl/tsp_regs.sv
module tsp_regs
  import tsp_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [PORT_W-1:0]               wdata,
  input  logic [PORT_W-1:0]               pad_in,
  output logic [PORT_W-1:0]               rdata,
  output logic [PORT_W-1:0]               pre,
  output logic [PORT_W-1:0]               func,
  output logic [PORT_W-1:0]               drv,
  output logic [PORT_W-1:0]               dir,
  output logic [NUM_NIB-1:0][1:0]         sel
);
  logic wr_data, wr_ctrl, wr_func, wr_drv, wr_dir;
  logic [PORT_W-1:0] ctrl_img;

  assign wr_data = wr_en && (addr == A_DATA);
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_func = wr_en && (addr == A_FUNC);
  assign wr_drv  = wr_en && (addr == A_DRV);
  assign wr_dir  = wr_en && (addr == A_DIR);

  // registers left uninitialized by reset
  always_ff @(posedge clk) begin
    if (wr_data) pre  <= wdata;
    if (wr_func) func <= wdata;
    if (wr_drv)  drv  <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir <= '0;
      sel <= '0;
    end else begin
      if (wr_dir) dir <= wdata;
      if (wr_ctrl) begin
        for (int n = 0; n < NUM_NIB; n++) sel[n] <= wdata[NIB_W*n +: 2];
      end
    end
  end

  always_comb begin
    ctrl_img = '0;
    for (int n = 0; n < NUM_NIB; n++) ctrl_img[NIB_W*n +: 2] = sel[n];
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_DATA:  rdata = pad_in;
        A_CTRL:  rdata = ctrl_img;
        A_FUNC:  rdata = func;
        A_DIR:   rdata = dir;
        default: rdata = '0;
      endcase
    end
  end

  AST_DIR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir == '0) && (sel == '0)); // R1
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0)); // R3
  AST_CTRL_GAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CTRL) |-> (rdata[7:6] == 2'b00) && (rdata[3:2] == 2'b00)); // R4
  AST_DRV_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_DRV) |-> (rdata == '0)); // R8
  AST_UNUSED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > A_DIR) |-> (rdata == '0)); // R10
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_DIR) |=> $stable(dir)); // R6
endmodule

// File: rtl/tsp_xfer.sv
module tsp_xfer
  import tsp_pkg::*;
#(
  parameter int W = NIB_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           sel,
  input  logic [NUM_STRB-1:0]  strb,
  input  logic [W-1:0]         pre_nib,
  output logic [W-1:0]         out_nib
);
  logic fire;

  assign fire = pick_strobe(sel, strb);

  always_ff @(posedge clk) begin
    if (fire) out_nib <= pre_nib;
  end

  AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (out_nib == $past(pre_nib))); // R5
  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(out_nib)); // R2
  AST_NO_STRB_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb == '0) |-> !fire); // R4
endmodule

// File: rtl/tsp_pad.sv
module tsp_pad
  import tsp_pkg::*;
#(
  parameter int PIN = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_bit,
  input  logic       func_bit,
  input  logic       drv_bit,
  input  logic       dir_bit,
  input  logic [1:0] alt_txd,
  input  logic [1:0] alt_sclk,
  output logic       pad_o,
  output logic       pad_oe
);
  localparam int KIND = alt_kind(PIN);

  logic alt_bit;
  logic use_alt;
  logic pin_val;

  generate
    if (KIND == ALT_TXD0)      begin : g_txd0 assign alt_bit = alt_txd[0];  end
    else if (KIND == ALT_TXD1) begin : g_txd1 assign alt_bit = alt_txd[1];  end
    else if (KIND == ALT_CLK0) begin : g_clk0 assign alt_bit = alt_sclk[0]; end
    else if (KIND == ALT_CLK1) begin : g_clk1 assign alt_bit = alt_sclk[1]; end
    else                       begin : g_none assign alt_bit = 1'b0;        end
  endgenerate

  assign use_alt = func_bit && (KIND != ALT_NONE);
  assign pin_val = use_alt ? alt_bit : port_bit;
  assign {pad_oe, pad_o} = pad_drive(pin_val, dir_bit, drv_bit);

  AST_PAD_IN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_bit |-> !pad_oe); // R6
  AST_PAD_OD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    drv_bit |-> !pad_o); // R7
  AST_PAD_PP_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_bit && !drv_bit) |-> pad_oe); // R7
  AST_PAD_NO_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == ALT_NONE && dir_bit && !drv_bit) |-> (pad_o == port_bit)); // R9
endmodule

// File: rtl/tsp_port.sv
module tsp_port
  import tsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic              strb_half,
  input  logic              strb_ta1,
  input  logic              strb_tb1,
  input  logic              strb_tb2,
  input  logic [1:0]        alt_txd,
  input  logic [1:0]        alt_sclk,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe
);
  logic [PORT_W-1:0]       pre, func, drv, dir, out_q;
  logic [NUM_NIB-1:0][1:0] sel;
  logic [NUM_STRB-1:0]     strb_vec;

  assign strb_vec = {strb_tb2, strb_tb1, strb_ta1, strb_half};

  tsp_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr),
    .rd_en  (bus_rd),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .pad_in (pad_in),
    .rdata  (bus_rdata),
    .pre    (pre),
    .func   (func),
    .drv    (drv),
    .dir    (dir),
    .sel    (sel)
  );

  generate
    for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
      tsp_xfer #(.W(NIB_W)) u_xfer (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel[n]),
        .strb    (strb_vec),
        .pre_nib (pre[NIB_W*n +: NIB_W]),
        .out_nib (out_q[NIB_W*n +: NIB_W])
      );
    end

    for (genvar p = 0; p < PORT_W; p++) begin : g_pin
      tsp_pad #(.PIN(p)) u_pad (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_bit (out_q[p]),
        .func_bit (func[p]),
        .drv_bit  (drv[p]),
        .dir_bit  (dir[p]),
        .alt_txd  (alt_txd),
        .alt_sclk (alt_sclk),
        .pad_o    (pad_out[p]),
        .pad_oe   (pad_oe[p])
      );
    end
  endgenerate

  AST_PORT_WR_NO_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_vec == '0) |=> $stable(out_q)); // R2
endmodule

// File: tb/sim_tsp_port.sv
module sim_tsp_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       strb_half = 1'b0, strb_ta1 = 1'b0, strb_tb1 = 1'b0, strb_tb2 = 1'b0;
  logic [1:0] alt_txd = '0, alt_sclk = '0;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;

  // reference model state
  logic [7:0] m_pre = '0, m_out = '0, m_func = '0, m_drv = '0, m_dir = '0;
  logic [1:0] m_lo = '0, m_hi = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsp_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .strb_half(strb_half), .strb_ta1(strb_ta1), .strb_tb1(strb_tb1), .strb_tb2(strb_tb2),
    .alt_txd(alt_txd), .alt_sclk(alt_sclk), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic bit strobe_for(logic [1:0] code);
    if (code == 2'b00) return strb_half;
    if (code == 2'b01) return strb_ta1;
    if (code == 2'b10) return strb_tb1;
    return strb_tb2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = '0; m_lo = '0; m_hi = '0;
    end else begin
      if (strobe_for(m_lo)) m_out[3:0] = m_pre[3:0];
      if (strobe_for(m_hi)) m_out[7:4] = m_pre[7:4];
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_pre = bus_wdata;
          3'd1: begin m_lo = bus_wdata[1:0]; m_hi = bus_wdata[5:4]; end
          3'd2: m_func = bus_wdata;
          3'd3: m_drv = bus_wdata;
          3'd4: m_dir = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] exp_pads();
    logic [7:0] o, oe;
    for (int i = 0; i < 8; i++) begin
      logic v;
      v = m_out[i];
      if (m_func[i]) begin
        if (i == 6) v = alt_txd[1];
        else if (i == 2) v = alt_txd[0];
        else if (i == 5 || i == 4) v = alt_sclk[1];
        else if (i == 1 || i == 0) v = alt_sclk[0];
      end
      oe[i] = m_dir[i] ? (m_drv[i] ? !v : 1'b1) : 1'b0;
      o[i]  = m_drv[i] ? 1'b0 : v;
    end
    return {oe, o};
  endfunction

  function automatic logic [7:0] exp_rd();
    if (!bus_rd) return 8'h00;
    case (bus_addr)
      3'd0: return pad_in;
      3'd1: return {2'b00, m_hi, 2'b00, m_lo};
      3'd2: return m_func;
      3'd4: return m_dir;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [15:0] e;
    #2;
    if (cmp_on && rst_n) begin
      e = exp_pads();
      chk("R5", "pad_out model", pad_out, e[7:0]);
      chk("R6", "pad_oe model", pad_oe, e[15:8]);
      chk("R3", "rdata model", bus_rdata, exp_rd());
    end
  end

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: strb_half = 1'b1;
      1: strb_ta1 = 1'b1;
      2: strb_tb1 = 1'b1;
      default: strb_tb2 = 1'b1;
    endcase
    @(negedge clk);
    strb_half = 1'b0; strb_ta1 = 1'b0; strb_tb1 = 1'b0; strb_tb2 = 1'b0;
    #1;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [7:0] exp, string tag);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    chk(tag, "read", bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "pad_oe after reset", pad_oe, 8'h00);
    rd_chk(3'd1, 8'h00, "R1");
    rd_chk(3'd4, 8'h00, "R1");

    wr_reg(3'd4, 8'hFF);
    wr_reg(3'd3, 8'h00);
    wr_reg(3'd2, 8'h00);
    wr_reg(3'd0, 8'h11);
    pulse(0);
    chk("R5", "half strobe load", pad_out, 8'h11);
    chk("R6", "all outputs", pad_oe, 8'hFF);
    cmp_on = 1'b1;

    wr_reg(3'd0, 8'hA5);
    repeat (3) @(negedge clk);
    #1;
    chk("R2", "preload only", pad_out, 8'h11);
    pulse(1);
    chk("R4", "unselected timer", pad_out, 8'h11);

    wr_reg(3'd1, 8'h21);
    rd_chk(3'd1, 8'h21, "R4");
    pulse(1);
    chk("R4", "lower on A1", pad_out, 8'h15);
    pulse(3);
    chk("R4", "B2 unselected", pad_out, 8'h15);
    pulse(2);
    chk("R4", "upper on B1", pad_out, 8'hA5);

    wr_reg(3'd1, 8'hFF);
    rd_chk(3'd1, 8'h33, "R4");
    wr_reg(3'd0, 8'h3C);
    pulse(3);
    chk("R4", "both on B2", pad_out, 8'h3C);
    wr_reg(3'd1, 8'h00);

    wr_reg(3'd0, 8'h90);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h77; strb_half = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; strb_half = 1'b0;
    #1;
    chk("R5", "same-cycle write uses old preload", pad_out, 8'h90);
    pulse(0);
    chk("R5", "new data on next strobe", pad_out, 8'h77);

    wr_reg(3'd4, 8'h0F);
    chk("R6", "direction mask", pad_oe, 8'h0F);
    rd_chk(3'd4, 8'h0F, "R6");

    wr_reg(3'd4, 8'hFF);
    wr_reg(3'd0, 8'h3C);
    pulse(0);
    wr_reg(3'd3, 8'hF0);
    chk("R7", "open-drain oe", pad_oe, 8'hCF);
    chk("R7", "open-drain out", pad_out, 8'h0C);
    rd_chk(3'd3, 8'h00, "R8");

    wr_reg(3'd3, 8'h00);
    alt_txd = 2'b10; alt_sclk = 2'b01;
    wr_reg(3'd2, 8'hFF);
    chk("R9", "alternate outputs", pad_out, 8'h4B);
    wr_reg(3'd2, 8'h88);
    chk("R9", "func bits 7,3 ignored", pad_out, 8'h3C);
    rd_chk(3'd2, 8'h88, "R9");

    pad_in = 8'h5A;
    rd_chk(3'd0, 8'h5A, "R3");
    bus_addr = 3'd0;
    #1;
    chk("R3", "no read enable", bus_rdata, 8'h00);

    wr_reg(3'd6, 8'hFF);
    rd_chk(3'd6, 8'h00, "R10");
    rd_chk(3'd2, 8'h88, "R10");

    // mixed traffic, checked against the model each cycle
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      strb_half = ~strb_half;
      strb_ta1 = ($urandom % 6) == 0;
      strb_tb1 = ($urandom % 7) == 0;
      strb_tb2 = ($urandom % 9) == 0;
      bus_wr = ($urandom % 4) == 0;
      bus_rd = ($urandom % 2) == 0;
      bus_addr = 3'($urandom % 8);
      bus_wdata = 8'($urandom);
      pad_in = 8'($urandom);
      alt_txd = 2'($urandom);
      alt_sclk = 2'($urandom);
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    strb_half = 1'b0; strb_ta1 = 1'b0; strb_tb1 = 1'b0; strb_tb2 = 1'b0;
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule